// File: doc/BRIEF.md
# Packet Bit-Stream Monitor Serializer

This block copies every 802.15.4 packet that the radio sends or receives onto a three-pin synchronous port, so that external capture hardware can build packet traces. The radio side presents packet bytes one at a time with a valid strobe. Each byte carries flags for first byte, last byte and transmit direction. The block holds these bytes in a small queue. It shifts them out least-significant bit first, one bit for each period of a slow bit clock derived from the system clock. Data and frame change when the bit clock falls, so a capture device can sample them on the rising edge.

The frame line carries packet boundaries and direction together. On a received packet it stays high for the whole packet. On a transmitted packet it pulses high only on the first bit and on the last bit. One idle bit slot always follows a packet. A single enable input switches the port on. While the port is off, the three pins carry the general-purpose I/O drive instead. The block is a pure observer. It never pushes back on the byte source, so the radio's own packet handling does not depend on it.

Top module: `pkt_bitstream_mon`

## Requirements
- R1: While `mon_en` is low, `mon_pins` equals `gpio_drv` bit for bit. While `mon_en` is high, `mon_pins[0]` is the bit clock, `mon_pins[1]` is serial data and `mon_pins[2]` is the frame line.
- R2: While enabled, the bit clock has a period of `CLK_DIV` system cycles, with `CLK_DIV/2` cycles high and `CLK_DIV/2` cycles low. It first rises `CLK_DIV/2` cycles after enable.
- R3: Data and frame change only in the cycle in which the bit clock falls.
- R4: Each byte is sent least-significant bit first, in the order the bytes were accepted. The bytes of one packet occupy consecutive bit slots while the queue does not run dry.
- R5: For a receive packet (`byte_tx` = 0), frame is high on every bit of the packet. It also stays high, with data 0, on slots where the queue runs dry inside the packet.
- R6: For a transmit packet (`byte_tx` = 1), frame is high only on bit 0 of the first byte and on bit 7 of the last byte.
- R7: The slot right after the last bit of a packet (`byte_eop` = 1) is idle, with data 0 and frame 0. This holds even if more bytes are waiting.
- R8: The queue holds `FIFO_DEPTH` (default 4) bytes. A byte offered while the queue is full is dropped and sets `ovf_flag`. The flag stays set until the block is disabled.
- R9: Disabling the block clears the queued bytes, any byte in progress and `ovf_flag`. Bytes offered while disabled are ignored.
- R10: Slots outside any packet carry data 0 and frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_en | input | 1 | Monitor enable control bit |
| byte_vld | input | 1 | Packet byte strobe |
| byte_data | input | 8 | Packet byte value |
| byte_sop | input | 1 | Byte is the first of its packet |
| byte_eop | input | 1 | Byte is the last of its packet |
| byte_tx | input | 1 | Packet is transmitted (1) or received (0) |
| gpio_drv | input | 3 | General-purpose drive for the three pins when disabled |
| mon_pins | output | 3 | Pin outputs: [0] bit clock, [1] data, [2] frame |
| ovf_flag | output | 1 | Sticky queue overflow flag |

## Verification
The in-line properties check, on every cycle, the high and low times of the bit clock, that data and frame move only when the clock falls, the frame level inside receive and transmit bytes, the idle slot after a last byte, and the dropping of a byte at a full queue together with the sticky flag. Only the bench's scenarios can show the bit order and byte reconstruction, the whole frame signature of a packet as a capture device sees it, the stall behaviour when the queue runs dry, and the flush on disable. These properties span many slots and depend on what the byte source offered.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
   localparam int BYTE_W = 8;

   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              sop;
      logic              eop;
      logic              tx;
   } bsm_entry_t;

   // frame level for bit k of a byte: receive packets hold it high,
   // transmit packets mark only the opening and closing bit
   function automatic logic frame_bit(input logic [2:0] k, input bsm_entry_t e);
      if (e.tx)
         return ((k == 3'd0) && e.sop) || ((k == 3'd7) && e.eop);
      else
         return 1'b1;
   endfunction
endpackage

// File: rtl/bsm_clkgen.sv
module bsm_clkgen #(
   parameter int CLK_DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic bclk,
   output logic fall_tick
);
   localparam int HALF  = CLK_DIV / 2;
   localparam int CNT_W = $clog2(CLK_DIV);

   logic [CNT_W-1:0] cnt;

   assign fall_tick = en && (cnt == CNT_W'(CLK_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         bclk <= 1'b0;
      end else if (!en) begin
         cnt  <= '0;
         bclk <= 1'b0;
      end else begin
         cnt <= fall_tick ? '0 : cnt + 1'b1;
         if (cnt == CNT_W'(HALF - 1)) bclk <= 1'b1;
         if (fall_tick)               bclk <= 1'b0;
      end
   end

   // independent run-length observer of the produced clock
   logic             bclk_seen;
   logic [CNT_W:0]   run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_seen <= 1'b0;
         run_len   <= '0;
      end else if (!en) begin
         bclk_seen <= 1'b0;
         run_len   <= '0;
      end else begin
         bclk_seen <= bclk;
         run_len   <= (bclk != bclk_seen) ? (CNT_W+1)'(1) : run_len + 1'b1;
      end
   end

   p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (bclk != bclk_seen)) |-> (run_len == (CNT_W+1)'(HALF)))
      else $error("bit clock half period wrong");
endmodule

// File: rtl/bsm_fifo.sv
module bsm_fifo #(
   parameter int DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                push_req,
   input  bsm_pkg::bsm_entry_t push_data,
   input  logic                pop,
   output logic                head_vld,
   output bsm_pkg::bsm_entry_t head,
   output logic                ovf
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   bsm_pkg::bsm_entry_t mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count;
   logic          full, push;

   assign full     = (count == CW'(DEPTH));
   assign push     = en && push_req && !full;
   assign head_vld = (count != '0);
   assign head     = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else if (!en) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         count <= count + CW'(push) - CW'(pop);
         if (push_req && full) ovf <= 1'b1;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && (wr_ptr == AW'(i))) mem[i] <= push_data;
      end
   end

   p_drop_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && push_req && full) |=> ((count + CW'($past(pop))) == $past(count)))
      else $error("byte stored into full queue");

   p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && $past(ovf)) |-> ovf)
      else $error("overflow flag cleared while enabled");

   p_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_vld)
      else $error("pop from empty queue");
endmodule

// File: rtl/bsm_shifter.sv
module bsm_shifter (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick,
   input  logic                head_vld,
   input  bsm_pkg::bsm_entry_t head,
   output logic                pop,
   output logic                sdata,
   output logic                sframe
);
   import bsm_pkg::*;

   bsm_entry_t cur;
   logic [2:0] idx;
   logic       busy, in_pkt, pkt_tx;
   logic       more, fin;

   always_comb begin
      more = busy && (idx != 3'd7);
      fin  = busy && (idx == 3'd7);
      pop  = tick && head_vld && !more && !(fin && cur.eop);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur    <= '0;
         idx    <= '0;
         busy   <= 1'b0;
         in_pkt <= 1'b0;
         pkt_tx <= 1'b0;
         sdata  <= 1'b0;
         sframe <= 1'b0;
      end else if (!en) begin
         cur    <= '0;
         idx    <= '0;
         busy   <= 1'b0;
         in_pkt <= 1'b0;
         pkt_tx <= 1'b0;
         sdata  <= 1'b0;
         sframe <= 1'b0;
      end else if (tick) begin
         if (more) begin
            idx    <= idx + 3'd1;
            sdata  <= cur.data[idx + 3'd1];
            sframe <= frame_bit(idx + 3'd1, cur);
         end else if (pop) begin
            cur    <= head;
            idx    <= 3'd0;
            busy   <= 1'b1;
            sdata  <= head.data[0];
            sframe <= frame_bit(3'd0, head);
            if (head.sop) begin
               in_pkt <= 1'b1;
               pkt_tx <= head.tx;
            end
         end else begin
            busy  <= 1'b0;
            sdata <= 1'b0;
            if (fin && cur.eop) begin
               in_pkt <= 1'b0;
               sframe <= 1'b0;
            end else begin
               sframe <= in_pkt && !pkt_tx;
            end
         end
      end
   end

   p_rx_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && !cur.tx) |-> sframe)
      else $error("receive frame dropped inside byte");

   p_tx_mid_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && busy && cur.tx && (idx != 3'd0) && (idx != 3'd7)) |-> !sframe)
      else $error("transmit frame high on inner bit");

   p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && tick && fin && cur.eop) |=> (!sframe && !sdata))
      else $error("no idle slot after last byte");
endmodule

// File: rtl/pkt_bitstream_mon.sv
module pkt_bitstream_mon #(
   parameter int CLK_DIV    = 128,
   parameter int FIFO_DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mon_en,
   input  logic       byte_vld,
   input  logic [7:0] byte_data,
   input  logic       byte_sop,
   input  logic       byte_eop,
   input  logic       byte_tx,
   input  logic [2:0] gpio_drv,
   output logic [2:0] mon_pins,
   output logic       ovf_flag
);
   import bsm_pkg::*;

   if ((CLK_DIV < 4) || ((CLK_DIV % 2) != 0)) begin : g_bad_div
      $error("CLK_DIV must be even and at least 4");
   end
   if ((FIFO_DEPTH < 2) || ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 2");
   end

   logic       bclk, tick, pop, head_vld, sdata, sframe;
   bsm_entry_t head, in_entry;

   assign in_entry = '{data: byte_data, sop: byte_sop, eop: byte_eop, tx: byte_tx};

   bsm_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk(clk), .rst_n(rst_n), .en(mon_en),
      .bclk(bclk), .fall_tick(tick));

   bsm_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .en(mon_en),
      .push_req(byte_vld), .push_data(in_entry), .pop(pop),
      .head_vld(head_vld), .head(head), .ovf(ovf_flag));

   bsm_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .en(mon_en), .tick(tick),
      .head_vld(head_vld), .head(head), .pop(pop),
      .sdata(sdata), .sframe(sframe));

   assign mon_pins = mon_en ? {sframe, sdata, bclk} : gpio_drv;

   p_change_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mon_en && $past(mon_en) &&
       (($past(sdata) != sdata) || ($past(sframe) != sframe))) |-> $fell(bclk))
      else $error("data or frame moved away from falling clock");
endmodule

// File: tb/test_pkt_bitstream_mon.sv
module test_pkt_bitstream_mon;
   localparam int DIV  = 8;
   localparam int HALF = DIV / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mon_en = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_data = '0;
   logic       byte_sop = 1'b0, byte_eop = 1'b0, byte_tx = 1'b0;
   logic [2:0] gpio_drv = '0;
   logic [2:0] mon_pins;
   logic       ovf_flag;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [1:0] slots[$];   // [1] frame, [0] data, one per rising bit clock
   logic       prev_bclk = 1'b0;
   logic [7:0] pkt_b[4];

   always #10 clk = ~clk;

   pkt_bitstream_mon #(.CLK_DIV(DIV), .FIFO_DEPTH(4)) i_pkt_bitstream_mon (
      .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .byte_vld(byte_vld),
      .byte_data(byte_data), .byte_sop(byte_sop), .byte_eop(byte_eop),
      .byte_tx(byte_tx), .gpio_drv(gpio_drv), .mon_pins(mon_pins),
      .ovf_flag(ovf_flag));

   always @(negedge clk) begin
      cycles <= cycles + 1;
      if (mon_en && mon_pins[0] && !prev_bclk) slots.push_back(mon_pins[2:1]);
      prev_bclk <= mon_en ? mon_pins[0] : 1'b0;
   end

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: act %0d cycles exp done", cycles);
         report();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
      end
   endtask

   task automatic push_byte(input logic [7:0] d, input logic s, input logic e,
                            input logic t);
      byte_vld = 1'b1; byte_data = d; byte_sop = s; byte_eop = e; byte_tx = t;
      @(negedge clk);
      byte_vld = 1'b0; byte_sop = 1'b0; byte_eop = 1'b0;
   endtask

   function automatic logic exp_frame(input int i, input int k, input int len,
                                      input logic tx);
      if (tx) return ((i == 0) && (k == 0)) || ((i == len - 1) && (k == 7));
      return 1'b1;
   endfunction

   task automatic check_stream(input int base, input int len, input logic tx);
      int f, idle_err, fr_err, g;
      logic [7:0] got;
      f = -1; idle_err = 0; fr_err = 0;
      for (int j = base; j < slots.size(); j++)
         if (slots[j][1] && f < 0) f = j;
      chk(f >= 0, tx ? "R6" : "R5", "packet start seen", f, base);
      if (f < 0) return;
      for (int j = base; j < f; j++) if (slots[j] != 2'b00) idle_err++;
      chk(idle_err == 0, "R10", "idle before packet", idle_err, 0);
      if (f + len * 8 >= slots.size()) begin
         chk(1'b0, "R4", "slot count", slots.size() - f, len * 8 + 1);
         return;
      end
      for (int i = 0; i < len; i++) begin
         for (int k = 0; k < 8; k++) begin
            got[k] = slots[f + i * 8 + k][0];
            if (slots[f + i * 8 + k][1] != exp_frame(i, k, len, tx)) fr_err++;
         end
         chk(got == pkt_b[i], "R4", "byte lsb first", got, pkt_b[i]);
      end
      chk(fr_err == 0, tx ? "R6" : "R5", "frame pattern", fr_err, 0);
      g = f + len * 8;
      chk(slots[g] == 2'b00, "R7", "idle slot after packet", slots[g], 0);
      idle_err = 0;
      for (int j = g + 1; j < slots.size(); j++) if (slots[j] != 2'b00) idle_err++;
      chk(idle_err == 0, "R10", "idle after packet", idle_err, 0);
   endtask

   task automatic send_pkt(input int len, input logic tx);
      int base;
      base = slots.size();
      for (int i = 0; i < len; i++) push_byte(pkt_b[i], i == 0, i == len - 1, tx);
      repeat ((len * 8 + 4) * DIV) @(negedge clk);
      check_stream(base, len, tx);
   endtask

   task automatic wait_fall();
      logic p;
      p = 1'b0;
      while (!(p && !mon_pins[0])) begin
         p = mon_pins[0];
         @(negedge clk);
      end
   endtask

   initial begin
      void'($urandom(32'h1f2e3d4c));
      gpio_drv = 3'b101;
      repeat (3) @(negedge clk);
      chk(mon_pins == gpio_drv, "R1", "pins in reset", mon_pins, gpio_drv);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ovf_flag == 1'b0, "R8", "overflow after reset", ovf_flag, 0);

      // R1: pins follow the general-purpose drive while disabled
      for (int n = 0; n < 4; n++) begin
         gpio_drv = 3'($urandom);
         @(negedge clk);
         chk(mon_pins == gpio_drv, "R1", "gpio passthrough", mon_pins, gpio_drv);
      end

      // R2: clock timing measured from the enable
      begin
         int t_rise, t_fall, t_rise2;
         t_rise = -1; t_fall = -1; t_rise2 = -1;
         mon_en = 1'b1;
         for (int n = 1; n <= 3 * DIV; n++) begin
            @(negedge clk);
            if (mon_pins[0] && t_rise < 0) t_rise = n;
            else if (!mon_pins[0] && t_rise >= 0 && t_fall < 0) t_fall = n;
            else if (mon_pins[0] && t_fall >= 0 && t_rise2 < 0) t_rise2 = n;
         end
         chk(t_rise == HALF, "R2", "first rise after enable", t_rise, HALF);
         chk(t_fall - t_rise == HALF, "R2", "high time", t_fall - t_rise, HALF);
         chk(t_rise2 - t_rise == DIV, "R2", "period", t_rise2 - t_rise, DIV);
      end

      // directed: single-byte receive and transmit packets
      pkt_b[0] = 8'h81;
      send_pkt(1, 1'b0);
      pkt_b[0] = 8'h3c;
      send_pkt(1, 1'b1);

      // random packets, R4 R5 R6 R7
      for (int p = 0; p < 24; p++) begin
         int len;
         logic tx;
         len = int'($urandom_range(1, 4));
         tx  = 1'($urandom);
         for (int i = 0; i < 4; i++) pkt_b[i] = 8'($urandom);
         send_pkt(len, tx);
      end

      // R8: six bytes into a four-entry queue between two ticks
      begin
         int base;
         for (int i = 0; i < 4; i++) pkt_b[i] = 8'($urandom);
         wait_fall();
         base = slots.size();
         for (int i = 0; i < 4; i++) push_byte(pkt_b[i], i == 0, i == 3, 1'b1);
         push_byte(8'hff, 1'b0, 1'b0, 1'b1);
         push_byte(8'hff, 1'b0, 1'b0, 1'b1);
         chk(ovf_flag == 1'b1, "R8", "overflow set", ovf_flag, 1);
         repeat (40 * DIV) @(negedge clk);
         check_stream(base, 4, 1'b1);
         chk(ovf_flag == 1'b1, "R8", "overflow sticky", ovf_flag, 1);
      end

      // R9: disable clears flag, flushes queue, ignores bytes offered while off
      begin
         int base, bad;
         for (int i = 0; i < 3; i++) push_byte(8'hff, i == 0, i == 2, 1'b0);
         repeat (2 * DIV) @(negedge clk);
         mon_en = 1'b0;
         gpio_drv = 3'b010;
         push_byte(8'hff, 1'b1, 1'b0, 1'b0);
         push_byte(8'hff, 1'b0, 1'b1, 1'b0);
         chk(mon_pins == gpio_drv, "R1", "pins while disabled", mon_pins, gpio_drv);
         chk(ovf_flag == 1'b0, "R9", "flag cleared by disable", ovf_flag, 0);
         mon_en = 1'b1;
         base = slots.size();
         repeat (40 * DIV) @(negedge clk);
         bad = 0;
         for (int j = base; j < slots.size(); j++) if (slots[j] != 2'b00) bad++;
         chk(bad == 0, "R9", "nothing sent after flush", bad, 0);
         chk(slots.size() - base >= 38, "R2", "clock runs after re-enable",
             slots.size() - base, 39);
      end

      // R5: receive stall keeps frame high with data 0
      begin
         int base, f, l, low, nz;
         logic [7:0] b0, b1;
         b0 = 8'ha5; b1 = 8'h5a;
         base = slots.size();
         push_byte(b0, 1'b1, 1'b0, 1'b0);
         repeat (20 * DIV) @(negedge clk);
         push_byte(b1, 1'b0, 1'b1, 1'b0);
         repeat (14 * DIV) @(negedge clk);
         f = -1; l = -1;
         for (int j = base; j < slots.size(); j++) if (slots[j][1]) begin
            if (f < 0) f = j;
            l = j;
         end
         chk(f >= 0 && (l - f + 1) >= 24, "R5", "frame span with stall", l - f + 1, 28);
         if (f >= 0 && (l - f + 1) >= 24 && l + 1 < slots.size()) begin
            logic [7:0] g0, g1;
            low = 0; nz = 0;
            for (int k = 0; k < 8; k++) begin
               g0[k] = slots[f + k][0];
               g1[k] = slots[l - 7 + k][0];
            end
            for (int j = f; j <= l; j++) if (!slots[j][1]) low++;
            for (int j = f + 8; j < l - 7; j++) if (slots[j][0]) nz++;
            chk(g0 == b0, "R4", "first byte before stall", g0, b0);
            chk(g1 == b1, "R4", "byte after stall", g1, b1);
            chk(low == 0, "R5", "frame low inside stalled packet", low, 0);
            chk(nz == 0, "R5", "data during stall", nz, 0);
            chk(slots[l + 1] == 2'b00, "R7", "idle after stalled packet", slots[l + 1], 0);
         end
      end

      report();
   end
endmodule